// File: doc/BRIEF.md
# Prescaled Interval Timer

A register-mapped interval timer that produces a timeout interrupt for a processor core. Software programs an 8-bit control register and a 16-bit down-counter over a simple register bus. The control register selects a power-of-two clock prescale ratio, turns counting on, picks one-shot or repeating operation, and can freeze the timer. Writing the counter sets both its live count and a hidden period register. The period register is what repeating mode reloads from.

The counter steps down once per prescaler tick. When the count moves from one to zero, the block raises a one-cycle interrupt pulse. In one-shot mode the counter then rests at zero until software writes it again. In repeating mode it starts the same interval over from the period register. An external disable input, driven by a separate power-control register, freezes the timer in the same way as the control register's own halt bit. Both control and counter values can be read at any time.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register and the counter read as zero and `timeout_irq` is low.
- R2: The control register stores write-data bits 7:0 and reads them back on bits 7:0, with bits 15:8 reading zero. Bit 7 is storage only and has no effect on timing.
- R3: Control bits 3:0 hold a prescale code N, and the counter steps once every 2^(N+1) clock cycles (N = 0 gives 2 cycles, N = 15 gives 65536 cycles).
- R4: A write with `bus_sel` = 1 loads the counter and the period register with the same value and restarts the prescale phase. A count of V therefore reaches zero V·2^(N+1) cycles after the write edge.
- R5: `timeout_irq` is high for exactly one cycle. That cycle directly follows the clock edge at which the count steps from 1 to 0.
- R6: With control bit 5 clear (one-shot), the counter stays at zero after expiring, and no further interrupt is raised until the counter is written again.
- R7: With control bit 5 set (repeat), the counter reloads from the period register on the same edge that it expires, and the interval repeats.
- R8: With control bit 4 (run) clear, the prescaler and the counter hold their state, and register writes are still accepted.
- R9: Setting control bit 6 (halt), or driving `ext_disable` high, freezes the prescaler and the counter in the same way as R8.
- R10: With `bus_re` high, `bus_rdata` returns the control register (`bus_sel` = 0) or the live count (`bus_sel` = 1). Reading does not disturb counting. With `bus_re` low, `bus_rdata` is zero.
- R11: Writing a count of zero raises no interrupt, in either mode.
- R12: A counter write that lands on the same edge as the terminal tick takes precedence. No interrupt is raised for the old interval, and the new count starts a fresh interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_sel | input | 1 | Register select: 0 = control, 1 = counter |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not reading |
| ext_disable | input | 1 | External freeze from the power-control logic |
| timeout_irq | output | 1 | One-cycle timeout interrupt pulse |

## Verification
A counter write and the prescaler's terminal tick can fall on the same clock edge. Only one of them can decide the next count and whether an interrupt fires. The bench provokes this by loading a short count at the fastest prescale, then timing a second counter write onto exactly the edge where the count would reach zero. The run is judged correct if no pulse appears at that edge and the next pulse arrives a full new interval later. A behavioural reference model, compared on every cycle, also covers the quieter overlaps: a read during counting, and a reload that coincides with expiry.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    // Control register layout, MSB first
    typedef struct packed {
        logic       spare;    // bit 7: storage only
        logic       halt;     // bit 6: freeze / power-down
        logic       rep_en;   // bit 5: repeat after expiry
        logic       run;      // bit 4: clock the prescaler
        logic [3:0] div_sel;  // bits 3:0: prescale code N
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_CNT  = 1'b1;

endpackage

// File: rtl/itmr_ctrl_reg.sv
module itmr_ctrl_reg
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output ctrl_t             ctrl_o
);

    typedef struct packed {
        ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.ctrl = ctrl_t'(wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;

    AST_CTRL_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ctrl_o == ctrl_t'($past(wdata_i)))  // R2
        else $error("control write not stored");

endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam int PRE_W = 1 << DIV_W;

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } state_t;

    state_t st_d, st_q;

    logic [DIV_W:0]   shamt;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] term;

    always_comb begin
        shamt  = {1'b0, div_i} + {{DIV_W{1'b0}}, 1'b1};
        span   = (PRE_W+1)'(1) << shamt;
        term   = span[PRE_W-1:0] - PRE_W'(1);
        // >= keeps a shrunk ratio from stalling when the phase is already past it
        tick_o = run_i && (st_q.phase >= term);

        st_d = st_q;
        if (restart_i) begin
            st_d.phase = '0;
        end else if (run_i) begin
            st_d.phase = tick_o ? '0 : st_q.phase + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o)  // R3
        else $error("prescaler ticked on consecutive cycles");

    AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> !tick_o || $past(tick_o))  // R8
        else $error("prescaler advanced while stopped");

endmodule

// File: rtl/itmr_downcount.sv
module itmr_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic             rep_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic             irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (load_i) begin
            // a write outranks a tick on the same edge
            st_d.cnt = load_val_i;
            st_d.per = load_val_i;
        end else if (tick_i && st_q.cnt != '0) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.irq = 1'b1;
                st_d.cnt = rep_i ? st_q.per : '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign irq_o   = st_q.irq;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o)  // R5
        else $error("interrupt longer than one cycle");

    AST_IRQ_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(count_o) == CNT_W'(1))  // R5
        else $error("interrupt without a 1-to-0 step");

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && count_o == '0) |=> count_o == '0 && !irq_o)  // R6
        else $error("idle counter moved");

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> count_o == ($past(rep_i) ? st_q.per : '0))  // R7
        else $error("wrong count after expiry");

    AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_o == $past(load_val_i) && st_q.per == $past(load_val_i) && !irq_o)  // R12
        else $error("counter write not taken");

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic             bus_sel,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ext_disable,
    output logic             timeout_irq
);

    localparam int PAD_W = CNT_W - CTRL_W;

    ctrl_t            ctrl;
    logic             wr_ctrl;
    logic             wr_cnt;
    logic             active;
    logic             tick;
    logic [CNT_W-1:0] count;

    always_comb begin
        wr_ctrl = bus_we && (bus_sel == SEL_CTRL);
        wr_cnt  = bus_we && (bus_sel == SEL_CNT);
        active  = ctrl.run && !ctrl.halt && !ext_disable;
    end

    itmr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_ctrl),
        .wdata_i (bus_wdata[CTRL_W-1:0]),
        .ctrl_o  (ctrl)
    );

    itmr_prescaler #(
        .DIV_W (DIV_W)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (active),
        .restart_i (wr_cnt),
        .div_i     (ctrl.div_sel),
        .tick_o    (tick)
    );

    itmr_downcount #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_cnt),
        .load_val_i (bus_wdata),
        .tick_i     (tick),
        .rep_i      (ctrl.rep_en),
        .count_o    (count),
        .irq_o      (timeout_irq)
    );

    always_comb begin
        if (!bus_re) begin
            bus_rdata = '0;
        end else if (bus_sel == SEL_CNT) begin
            bus_rdata = count;
        end else begin
            bus_rdata = {{PAD_W{1'b0}}, ctrl};
        end
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !wr_cnt) |=> $stable(count) && !timeout_irq)  // R9
        else $error("counter moved while frozen");

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_sel == SEL_CTRL) |-> bus_rdata[CNT_W-1:CTRL_W] == '0)  // R2
        else $error("unstored control bits read non-zero");

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> bus_rdata == '0)  // R10
        else $error("read data driven without read strobe");

endmodule

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic        bus_sel = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        ext_disable = 1'b0;
    logic [15:0] bus_rdata;
    logic        timeout_irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // behavioural reference state
    int m_ctrl = 0, m_cnt = 0, m_per = 0, m_phase = 0;
    bit m_irq = 0;

    always #2 clk = ~clk;  // 250 MHz

    interval_timer u_interval_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_re      (bus_re),
        .bus_sel     (bus_sel),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ext_disable (ext_disable),
        .timeout_irq (timeout_irq)
    );

    task automatic check(string req, bit ok, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cnt = 0; m_per = 0; m_phase = 0; m_irq = 0;
        end else begin
            int  ratio;
            bit  go, tk;
            ratio = 1 << ((m_ctrl & 15) + 1);
            go    = ((m_ctrl >> 4) & 1) && !((m_ctrl >> 6) & 1) && !ext_disable;
            tk    = go && (m_phase >= ratio - 1);
            m_irq = 0;
            if (bus_we && bus_sel) begin
                m_cnt = bus_wdata; m_per = bus_wdata; m_phase = 0;
            end else begin
                if (tk && m_cnt != 0) begin
                    if (m_cnt == 1) begin
                        m_irq = 1;
                        m_cnt = ((m_ctrl >> 5) & 1) ? m_per : 0;
                    end else begin
                        m_cnt = m_cnt - 1;
                    end
                end
                if (go) m_phase = tk ? 0 : m_phase + 1;
            end
            if (bus_we && !bus_sel) m_ctrl = bus_wdata & 255;
        end
    end

    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            int exp_rd;
            exp_rd = !bus_re ? 0 : (bus_sel ? m_cnt : m_ctrl);
            check("R5 irq vs model", timeout_irq == m_irq, timeout_irq, m_irq);
            check("R10 rdata vs model", bus_rdata == exp_rd, bus_rdata, exp_rd);
        end
    end

    // caller stands at a negedge; returns at the negedge after the write edge
    task automatic wr(bit sel, logic [15:0] data);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(bit sel, output int v);
        bus_re = 1'b1; bus_sel = sel;
        #1;
        v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_irq(int max, output int n);
        n = 0;
        while (n < max && !timeout_irq) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic watch(int cyc, output int p);
        p = 0;
        repeat (cyc) begin
            @(negedge clk);
            if (timeout_irq) p++;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int v, v2, n, p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); check("R1 ctrl after reset", v == 0, v, 0);
        rd(1, v); check("R1 count after reset", v == 0, v, 0);
        check("R1 irq after reset", timeout_irq == 0, timeout_irq, 0);

        // R2 readback, upper bits dropped
        wr(0, 16'h01A3);
        rd(0, v); check("R2 ctrl readback", v == 'hA3, v, 'hA3);

        // R3/R4 with spare bit 7 set (R2: no effect): N=0, count 3 -> 6 cycles
        wr(0, 16'h0090);
        wr(1, 16'd3);
        wait_irq(200, n); check("R4 interval N=0 V=3", n == 6, n, 6);
        @(negedge clk);
        check("R5 pulse one cycle", timeout_irq == 0, timeout_irq, 0);

        // R6 one-shot idles at zero
        watch(30, p); check("R6 no second pulse", p == 0, p, 0);
        rd(1, v); check("R6 count rests at zero", v == 0, v, 0);

        // R3 N=2 (ratio 8), count 5 -> 40 cycles
        wr(0, 16'h0012);
        wr(1, 16'd5);
        wait_irq(200, n); check("R3 interval N=2 V=5", n == 40, n, 40);

        // R7 repeat, N=1 (ratio 4), count 3
        wr(0, 16'h0031);
        wr(1, 16'd3);
        wait_irq(200, n); check("R7 first interval", n == 12, n, 12);
        rd(1, v); check("R7 reloaded count", v == 3, v, 3);
        wait_irq(200, n); check("R7 second interval", n == 11, n, 11);

        // R8 run clear freezes
        wr(0, 16'h0021);
        rd(1, v); watch(50, p); rd(1, v2);
        check("R8 count held", v2 == v, v2, v);
        check("R8 no pulse", p == 0, p, 0);

        // R9 halt bit freezes
        wr(0, 16'h0071);
        rd(1, v); watch(50, p); rd(1, v2);
        check("R9 halt holds count", v2 == v && p == 0, v2, v);

        // R9 external disable freezes
        wr(0, 16'h0011);
        ext_disable = 1'b1;
        rd(1, v); watch(50, p); rd(1, v2);
        check("R9 ext_disable holds count", v2 == v && p == 0, v2, v);
        ext_disable = 1'b0;
        watch(20, p);

        // R11 zero count never interrupts, one-shot and repeat
        wr(1, 16'd0);
        watch(60, p); check("R11 zero one-shot", p == 0, p, 0);
        wr(0, 16'h0030);
        wr(1, 16'd0);
        watch(60, p); check("R11 zero repeat", p == 0, p, 0);

        // R10 reading throughout does not disturb: N=1, V=4 -> 16 cycles
        wr(0, 16'h0011);
        wr(1, 16'd4);
        bus_re = 1'b1; bus_sel = 1'b1;
        wait_irq(200, n);
        bus_re = 1'b0;
        check("R10 interval while reading", n == 16, n, 16);
        #1; check("R10 idle bus reads zero", bus_rdata == 0, bus_rdata, 0);
        @(negedge clk);

        // R12 write on the terminal edge wins: N=0, V=2 expires at edge +4
        wr(0, 16'h0010);
        wr(1, 16'd2);
        repeat (3) @(negedge clk);
        wr(1, 16'd5);
        wait_irq(200, n); check("R12 collision then fresh interval", n == 10, n, 10);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule